// File: doc/BRIEF.md
# Two-Phase Column Conversion Controller

This block is the digital half of one column of a multiple-ramp single-slope converter. It sequences each conversion. First comes a coarse phase, in which the column is forced onto ramp 0. It then enters a fine phase, in which the stored coarse code selects one of the concurrently running ramps. In each phase the block captures an internal phase count on the first rising edge of the comparator output. The comparator, the analog switches and the ramps sit outside the block. They are represented only by the comparator input and by the force-select and one-hot ramp-select outputs.

A line-start pulse begins a conversion and swaps the two result banks. The bank that is not converting is shown on the read port, so the result of the previous line can be read out while the current line converts. Three conversion modes are offered. Multiple-ramp mode has a 128-count fine phase. Companding mode has a 64-count fine phase. Single-slope mode runs one 1024-count phase on ramp 0 only.

Top module: `colconv_top`

## Requirements
- R1: After reset, busy is 0, forceSel is 1, rampSel is 8'b0000_0001 and rdData is 0.
- R2: Whenever forceSel is 1, rampSel selects ramp 0 (bit 0 only). forceSel is 1 in every cycle outside the fine phase, including idle.
- R3: During the fine phase, rampSel is one-hot with the bit set at the stored coarse code, and it does not change for the whole phase.
- R4: The coarse phase lasts 8 cycles, counted 0 to 7. The stored coarse code is the count at the first cycle the comparator is sampled rising, and later rising edges in the same phase are ignored.
- R5: If the comparator never rises in a phase, that phase stores its full-scale count: 7 for coarse, 127 or 63 for fine, and 1023 for single-slope.
- R6: modeSel 2'b00 or 2'b11 gives a 128-cycle fine phase, and modeSel 2'b01 gives a 64-cycle fine phase. The fine code is captured like the coarse code, counting from 0.
- R7: modeSel 2'b10 (single-slope) runs one 1024-cycle phase with forceSel held at 1 throughout. The code goes to the fine field and the coarse field is 0.
- R8: A lineStart sampled while idle starts a conversion in the next cycle and swaps banks. rdData then shows the last completed conversion as {coarse[2:0] in bits 12:10, fine[9:0] in bits 9:0}.
- R9: rdData does not change while a conversion is in progress.
- R10: A lineStart sampled while busy is ignored. This includes the final cycle of a conversion: there is no swap and no restart.
- R11: A comparator already high in the first cycle of a phase counts as a rise in that phase, so the captured code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStart | input | 1 | Start-of-line pulse; starts a conversion and swaps banks when idle |
| modeSel | input | 2 | 00/11 multiple-ramp, 01 companding, 10 single-slope; sampled with lineStart |
| compOut | input | 1 | Column comparator output |
| busy | output | 1 | Conversion in progress |
| forceSel | output | 1 | High when ramp 0 is forced; low only in the fine phase |
| rampSel | output | 8 | One-hot ramp switch enables |
| rdData | output | 13 | Readout bank: {coarse[2:0], fine[9:0]} |

## Verification
The delicate overlap is a line-start arriving on the very edge at which the last fine count is captured. On that edge the conversion is still busy, so the pulse must neither swap banks nor restart. The bench raises lineStart exactly there, confirms that rdData still shows the bank that was readable before, and then issues a proper line-start. The scoreboard expects the swap to expose the conversion that finished under the ignored pulse. A second overlap is a comparator that is still high from the coarse phase when the fine phase begins. That case has to give a fine code of 0, not be lost.

// File: rtl/colconv_pkg.sv
package colconv_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_COARSE, PH_FINE, PH_SINGLE} phase_e;
  typedef enum logic [1:0] {
    MD_MULTI   = 2'b00,
    MD_COMPAND = 2'b01,
    MD_SINGLE  = 2'b10,
    MD_MULTI2  = 2'b11
  } mode_e;
  typedef struct packed {
    logic swapBank;
    logic wrCoarse;
    logic wrFine;
    logic useStored;
  } strobe_t;
endpackage

// File: rtl/colconv_ctrl.sv
module colconv_ctrl
  import colconv_pkg::*;
#(
  parameter int RAMPS        = 8,
  parameter int FINE_MR_LEN  = 128,
  parameter int FINE_CMP_LEN = 64,
  parameter int SS_LEN       = 1024,
  localparam int CNT_W = $clog2(SS_LEN),
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic [1:0]       modeIn,
  input  logic             compOut,
  output strobe_t          strb,
  output logic [CNT_W-1:0] cntVal,
  output logic             busy
);
  phase_e           phase;
  mode_e            modeQ;
  logic [CNT_W-1:0] cnt;
  logic             compPrev;
  logic             tripped;
  logic [LEN_W-1:0] phaseLen;
  logic             lastCnt;
  logic             rise;

  always_comb begin
    case (phase)
      PH_COARSE: phaseLen = LEN_W'(RAMPS);
      PH_FINE:   phaseLen = (modeQ == MD_COMPAND) ? LEN_W'(FINE_CMP_LEN) : LEN_W'(FINE_MR_LEN);
      default:   phaseLen = LEN_W'(SS_LEN);
    endcase
  end

  assign lastCnt = ({1'b0, cnt} == (phaseLen - LEN_W'(1)));
  assign rise    = compOut & ~compPrev & ~tripped;

  // full-scale store on the last count equals the count itself
  assign strb.wrCoarse  = (phase == PH_COARSE) & (rise | (lastCnt & ~tripped));
  assign strb.wrFine    = ((phase == PH_FINE) | (phase == PH_SINGLE)) & (rise | (lastCnt & ~tripped));
  assign strb.swapBank  = (phase == PH_IDLE) & lineStart;
  assign strb.useStored = (phase == PH_FINE);
  assign cntVal = cnt;
  assign busy   = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      modeQ    <= MD_MULTI;
      cnt      <= '0;
      compPrev <= 1'b0;
      tripped  <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (lineStart) begin
        modeQ    <= mode_e'(modeIn);
        phase    <= (mode_e'(modeIn) == MD_SINGLE) ? PH_SINGLE : PH_COARSE;
        cnt      <= '0;
        compPrev <= 1'b0;
        tripped  <= 1'b0;
      end
    end else if (lastCnt) begin
      cnt      <= '0;
      compPrev <= 1'b0;
      tripped  <= 1'b0;
      phase    <= (phase == PH_COARSE) ? PH_FINE : PH_IDLE;
    end else begin
      cnt      <= cnt + CNT_W'(1);
      compPrev <= compOut;
      if (rise) tripped <= 1'b1;
    end
  end
endmodule

// File: rtl/colconv_data.sv
module colconv_data
  import colconv_pkg::*;
#(
  parameter int RAMPS  = 8,
  parameter int FINE_W = 10,
  parameter int CNT_W  = 10,
  localparam int SEL_W = $clog2(RAMPS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [CNT_W-1:0]        cntVal,
  output logic [RAMPS-1:0]        rampSel,
  output logic [SEL_W+FINE_W-1:0] rdData
);
  logic [SEL_W-1:0]  coarseMem [2];
  logic [FINE_W-1:0] fineMem   [2];
  logic              convBank;
  logic [SEL_W-1:0]  selCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convBank <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        coarseMem[b] <= '0;
        fineMem[b]   <= '0;
      end
    end else if (strb.swapBank) begin
      convBank             <= ~convBank;
      coarseMem[~convBank] <= '0;
      fineMem[~convBank]   <= '0;
    end else begin
      if (strb.wrCoarse) coarseMem[convBank] <= cntVal[SEL_W-1:0];
      if (strb.wrFine)   fineMem[convBank]   <= FINE_W'(cntVal);
    end
  end

  assign selCode = strb.useStored ? coarseMem[convBank] : '0;

  for (genvar g = 0; g < RAMPS; g++) begin : g_dec
    assign rampSel[g] = (selCode == SEL_W'(g));
  end

  assign rdData = {coarseMem[~convBank], fineMem[~convBank]};
endmodule

// File: rtl/colconv_top.sv
module colconv_top
  import colconv_pkg::*;
#(
  parameter int RAMPS        = 8,
  parameter int FINE_W       = 10,
  parameter int FINE_MR_LEN  = 128,
  parameter int FINE_CMP_LEN = 64,
  parameter int SS_LEN       = 1024,
  localparam int SEL_W = $clog2(RAMPS),
  localparam int CNT_W = $clog2(SS_LEN)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lineStart,
  input  logic [1:0]              modeSel,
  input  logic                    compOut,
  output logic                    busy,
  output logic                    forceSel,
  output logic [RAMPS-1:0]        rampSel,
  output logic [SEL_W+FINE_W-1:0] rdData
);
  strobe_t          strb;
  logic [CNT_W-1:0] cntVal;

  colconv_ctrl #(
    .RAMPS(RAMPS), .FINE_MR_LEN(FINE_MR_LEN),
    .FINE_CMP_LEN(FINE_CMP_LEN), .SS_LEN(SS_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .modeIn(modeSel),
    .compOut(compOut), .strb(strb), .cntVal(cntVal), .busy(busy)
  );

  colconv_data #(.RAMPS(RAMPS), .FINE_W(FINE_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal),
    .rampSel(rampSel), .rdData(rdData)
  );

  assign forceSel = ~strb.useStored;
endmodule

// File: rtl/colconv_chk.sv
module colconv_chk #(
  parameter int RAMPS       = 8,
  parameter int DATA_W      = 13,
  parameter int FINE_MR_LEN = 128,
  localparam int RUN_W = $clog2(FINE_MR_LEN) + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStart,
  input logic              busy,
  input logic              forceSel,
  input logic [RAMPS-1:0]  rampSel,
  input logic [DATA_W-1:0] rdData
);
  logic [RUN_W-1:0] fineRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fineRun <= '0;
    else if (forceSel) fineRun <= '0;
    else if (fineRun != '1) fineRun <= fineRun + RUN_W'(1);
  end

  p_ramp0_forced_r2: assert property (@(posedge clk) disable iff (!rstN)
    forceSel |-> (rampSel == RAMPS'(1)));
  p_idle_forced_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> forceSel);
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    !forceSel |-> $onehot(rampSel));
  p_sel_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!forceSel && $past(!forceSel)) |-> $stable(rampSel));
  p_fine_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    fineRun <= RUN_W'(FINE_MR_LEN));
  p_read_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdData));
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lineStart) |=> $stable(rdData));
endmodule

bind colconv_top colconv_chk #(
  .RAMPS(RAMPS), .DATA_W(SEL_W + FINE_W), .FINE_MR_LEN(FINE_MR_LEN)
) u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .busy(busy),
  .forceSel(forceSel), .rampSel(rampSel), .rdData(rdData)
);

// File: tb/sim_colconv_top.sv
`timescale 1ns/1ps
module sim_colconv_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic        compOut = 1'b0;
  logic        busy;
  logic        forceSel;
  logic [7:0]  rampSel;
  logic [12:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [12:0] expQ[$];
  logic [12:0] heldRd;
  event swapEv;

  always #4 clk = ~clk;

  colconv_top u0 (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .modeSel(modeSel),
    .compOut(compOut), .busy(busy), .forceSel(forceSel),
    .rampSel(rampSel), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic compGen(input int cn, input int tgt, input bit glitch);
    logic v;
    v = (cn >= tgt);
    if (glitch && cn == tgt + 1) v = 1'b0;
    return v;
  endfunction

  // monitor: on each swap, the read port must show the oldest queued result
  initial begin
    forever begin
      logic [12:0] e;
      @(swapEv);
      e = (expQ.size() > 0) ? expQ.pop_front() : 13'h0;
      chk(rdData == e, "R8 readout after swap", int'(rdData), int'(e));
    end
  end

  task automatic convert(input logic [1:0] md, input int c, input int f,
                         input bit glitch, input bit collide);
    bit ss;
    int L, T, fineLow, expC, expF;
    bit selBad, ffBad, roBad;
    ss = (md == 2'b10);
    L = ss ? 1024 : ((md == 2'b01) ? 64 : 128);
    T = ss ? 1024 : 8 + L;
    expC = ss ? 0 : ((c < 8) ? c : 7);
    expF = (f < L) ? f : L - 1;
    fineLow = 0; selBad = 0; ffBad = 0; roBad = 0;
    @(negedge clk); lineStart = 1'b1; modeSel = md; compOut = 1'b0;
    @(negedge clk); lineStart = 1'b0;
    ->swapEv;
    heldRd = rdData;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    for (int k = 1; k <= T; k++) begin
      if (!ss && k <= 8) compOut = compGen(k - 1, c, glitch);
      else               compOut = compGen(ss ? k - 1 : k - 9, f, glitch);
      if (!forceSel) begin
        fineLow++;
        if (rampSel != (8'd1 << expC)) selBad = 1;
      end else if (rampSel != 8'd1) ffBad = 1;
      if (rdData != heldRd) roBad = 1;
      if (collide && k == T) lineStart = 1'b1;
      @(negedge clk);
    end
    lineStart = 1'b0;
    compOut = 1'b0;
    chk(busy == 1'b0, ss ? "R7 single phase length" : "R6 conversion length", int'(busy), 0);
    chk(fineLow == (ss ? 0 : L), ss ? "R7 forceSel held" : "R6 fine phase cycles", fineLow, ss ? 0 : L);
    chk(!selBad, "R3 fine rampSel at coarse code", int'(selBad), 0);
    chk(!ffBad, "R2 ramp 0 when forced", int'(ffBad), 0);
    chk(!roBad, "R9 readout frozen during conversion", int'(roBad), 0);
    if (collide) begin
      @(negedge clk);
      chk(rdData == heldRd, "R10 start while busy ignored", int'(rdData), int'(heldRd));
      chk(busy == 1'b0, "R10 no restart", int'(busy), 0);
    end
    expQ.push_back({3'(expC), 10'(expF)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    expQ.push_back(13'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(forceSel == 1'b1, "R1 reset forceSel", int'(forceSel), 1);
    chk(rampSel == 8'd1, "R1 reset rampSel", int'(rampSel), 1);
    chk(rdData == 13'd0, "R1 reset rdData", int'(rdData), 0);

    convert(2'b00, 5, 100, 0, 0);    // R4 R6 multiple-ramp
    convert(2'b01, 2, 40, 0, 0);     // R6 companding
    convert(2'b00, 9, 200, 0, 0);    // R5 no trip -> 7, 127
    convert(2'b01, 0, 70, 0, 0);     // R5 fine full scale 63
    convert(2'b00, 3, 0, 0, 0);      // R11 comparator high at fine start
    convert(2'b00, 6, 50, 1, 0);     // R4 later rise ignored
    convert(2'b10, 0, 700, 0, 0);    // R7 single-slope
    convert(2'b10, 0, 2000, 0, 0);   // R5 R7 single-slope full scale
    convert(2'b00, 1, 127, 0, 1);    // R10 start on final capture edge
    convert(2'b11, 4, 10, 0, 0);     // R6 mode 11 as multiple-ramp
    convert(2'b00, 7, 0, 0, 0);      // flush previous result
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule